// File: doc/BRIEF.md
# Floating-Point Result Condition-Code and Exception Controller

This block sits after the add/subtract datapath of a floating-point unit. It does no arithmetic. It takes status about the raw result: the sign, whether the result is zero, whether the exponent underflowed, and how many hexadecimal digit positions of left shift normalization needed. It also takes three mode bits. The first turns normalization off, the second selects trapping on underflow, and the third selects trapping on loss of significance. From these it produces a 4-bit condition code and three control flags. The first flag forces the stored result to true zero. The second requests a trap to a fixed vector. The third allows the general registers to be written.

The decision is made by combinational logic and captured in one output register stage. A transaction is offered by raising `in_valid` for a cycle. The verdict appears on the next cycle together with `out_valid`. The registered outputs hold their last verdict until the next transaction. The trap vector address is a constant output.

Top module: `fpx_cc_ctrl`

## Requirements
- R1: With `md_nrm_off`=1, `md_uf_trap`, `md_sig_trap`, `res_underflow` and `res_lshift` have no effect. A zero result gives cc=4'b0000 with force_true_zero=1. Otherwise cc=4'b0010 for a positive result and 4'b0001 for a negative result. There is no trap in this mode.
- R2: With normalization on, no underflow, a non-zero result and `res_lshift` of at most 2, cc=4'b0010 for positive (`res_sign`=0) and 4'b0001 for negative. There is no trap and no forced zero, and gr_write_en=1.
- R3: With normalization on, `md_uf_trap`=0 and underflow, and no significance trap per R7, force_true_zero=1 and cc=4'b1100. There is no trap.
- R4: With normalization on, `md_uf_trap`=1 and underflow, trap_req=1 and gr_write_en=0. cc=4'b1110 for positive and 4'b1101 for negative.
- R5: With normalization on, `md_sig_trap`=0, no underflow and a zero result, force_true_zero=1 and cc=4'b1000. There is no trap.
- R6: With normalization on, `md_sig_trap`=0, no underflow, a non-zero result and `res_lshift` greater than 2, cc=4'b1010 for positive and 4'b1001 for negative. There is no trap and no forced zero.
- R7: With normalization on and `md_sig_trap`=1, a zero result or `res_lshift` greater than 2 raises trap_req=1 with gr_write_en=0, unless R9 applies. cc=4'b1000 for zero, 4'b1010 for positive and 4'b1001 for negative.
- R8: When a significance trap (R7) is raised with `md_uf_trap`=0, a simultaneous underflow is ignored. The code from R7 is produced and force_true_zero=0.
- R9: When an underflow trap (R4) is raised with `md_uf_trap`=1, the significance condition is ignored. The code from R4 is produced.
- R10: trap_req and gr_write_en are never both 1, and trap_vector is the constant 8'h44.
- R11: out_valid is 1 exactly in the cycle after a cycle with in_valid=1. The cc and flag outputs change only in the cycle after in_valid=1, and all outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Result status and modes are valid this cycle |
| res_sign | input | 1 | Result sign, 1 = negative |
| res_zero | input | 1 | Result fraction is zero |
| res_underflow | input | 1 | Exponent underflowed during normalization |
| res_lshift | input | SHIFT_W | Hex-digit left shifts needed to normalize |
| md_nrm_off | input | 1 | Normalization inhibited |
| md_uf_trap | input | 1 | Trap on underflow instead of zeroing |
| md_sig_trap | input | 1 | Trap on significance loss |
| out_valid | output | 1 | Verdict valid |
| cc | output | 4 | Condition code |
| force_true_zero | output | 1 | Replace result with true zero |
| trap_req | output | 1 | Trap to the fixed vector |
| gr_write_en | output | 1 | General registers may be written |
| trap_vector | output | VEC_W | Constant trap vector address |

## Verification
Directed cases cover each mode combination, with a zero result, a positive result and a negative result. These separate the seven condition-code encodings and the sign selection within each. Shift counts of 2 and 3 probe the significance threshold. Underflow is combined with a significance condition under both settings of the underflow mode, which shows which trap wins in R8 and R9. Random mixes of all inputs, including underflow and shift while normalization is off, check the ignored inputs and the mutual exclusion of trap and write. Idle cycles with changing inputs show that the outputs hold.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int CC_W = 4;

    typedef struct packed {
        logic nrm_off;
        logic uf_trap;
        logic sig_trap;
    } fpx_mode_t;

    typedef struct packed {
        logic sign;
        logic is_zero;
        logic underflow;
        logic heavy_shift;
    } fpx_stat_t;

    typedef enum logic [2:0] {
        V_PLAIN    = 3'd0,
        V_INH_ZERO = 3'd1,
        V_UF_ZERO  = 3'd2,
        V_UF_TRAP  = 3'd3,
        V_SIG_TRAP = 3'd4,
        V_SIG_ZERO = 3'd5,
        V_SIG_NOTE = 3'd6
    } fpx_case_e;

    typedef struct packed {
        logic [CC_W-1:0] cc;
        logic            trap;
        logic            gr_write;
        logic            force_zero;
    } fpx_verdict_t;

    // Priority: significance trap (only when underflow trap not taken),
    // then underflow handling, then non-trapping significance reports.
    function automatic fpx_case_e classify(input fpx_mode_t m, input fpx_stat_t s);
        logic sig_cond;
        sig_cond = s.is_zero | s.heavy_shift;
        if (m.nrm_off)
            return s.is_zero ? V_INH_ZERO : V_PLAIN;
        if (m.sig_trap && sig_cond && !(s.underflow && m.uf_trap))
            return V_SIG_TRAP;
        if (s.underflow)
            return m.uf_trap ? V_UF_TRAP : V_UF_ZERO;
        if (s.is_zero)
            return V_SIG_ZERO;
        if (s.heavy_shift)
            return V_SIG_NOTE;
        return V_PLAIN;
    endfunction

    function automatic logic [1:0] sign_bits(input logic neg);
        return neg ? 2'b01 : 2'b10;
    endfunction

    function automatic fpx_verdict_t verdict_of(input fpx_case_e c, input fpx_stat_t s);
        fpx_verdict_t v;
        v.trap       = 1'b0;
        v.force_zero = 1'b0;
        v.cc         = {2'b00, sign_bits(s.sign)};
        case (c)
            V_INH_ZERO: begin
                v.cc         = 4'b0000;
                v.force_zero = 1'b1;
            end
            V_UF_ZERO: begin
                v.cc         = 4'b1100;
                v.force_zero = 1'b1;
            end
            V_UF_TRAP: begin
                v.cc   = {2'b11, sign_bits(s.sign)};
                v.trap = 1'b1;
            end
            V_SIG_TRAP: begin
                v.cc   = s.is_zero ? 4'b1000 : {2'b10, sign_bits(s.sign)};
                v.trap = 1'b1;
            end
            V_SIG_ZERO: begin
                v.cc         = 4'b1000;
                v.force_zero = 1'b1;
            end
            V_SIG_NOTE: v.cc = {2'b10, sign_bits(s.sign)};
            default:    v.cc = {2'b00, sign_bits(s.sign)};
        endcase
        v.gr_write = ~v.trap;
        return v;
    endfunction

endpackage

// File: rtl/fpx_stat_pack.sv
module fpx_stat_pack
    import fpx_pkg::*;
#(
    parameter int SHIFT_W   = 3,
    parameter int SIG_LIMIT = 2
) (
    input  logic               sign,
    input  logic               is_zero,
    input  logic               underflow,
    input  logic [SHIFT_W-1:0] lshift,
    output fpx_stat_t          stat
);
    localparam logic [SHIFT_W-1:0] LIMIT = SHIFT_W'(SIG_LIMIT);

    always_comb begin
        stat.sign        = sign;
        stat.is_zero     = is_zero;
        stat.underflow   = underflow;
        stat.heavy_shift = (lshift > LIMIT);
    end
endmodule

// File: rtl/fpx_decide.sv
module fpx_decide
    import fpx_pkg::*;
(
    input  fpx_mode_t    mode,
    input  fpx_stat_t    stat,
    output fpx_verdict_t verdict
);
    fpx_case_e kind;

    always_comb begin
        kind    = classify(mode, stat);
        verdict = verdict_of(kind, stat);
    end
endmodule

// File: rtl/fpx_out_stage.sv
module fpx_out_stage
    import fpx_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  fpx_verdict_t verdict_d,
    output logic         valid_q,
    output fpx_verdict_t verdict_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= '0;
        end else begin
            valid_q <= load;
            if (load)
                verdict_q <= verdict_d;
        end
    end
endmodule

// File: rtl/fpx_cc_ctrl.sv
module fpx_cc_ctrl
    import fpx_pkg::*;
#(
    parameter int              SHIFT_W   = 3,
    parameter int              SIG_LIMIT = 2,
    parameter int              VEC_W     = 8,
    parameter logic [VEC_W-1:0] TRAP_VEC = 8'h44
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               res_sign,
    input  logic               res_zero,
    input  logic               res_underflow,
    input  logic [SHIFT_W-1:0] res_lshift,
    input  logic               md_nrm_off,
    input  logic               md_uf_trap,
    input  logic               md_sig_trap,
    output logic               out_valid,
    output logic [CC_W-1:0]    cc,
    output logic               force_true_zero,
    output logic               trap_req,
    output logic               gr_write_en,
    output logic [VEC_W-1:0]   trap_vector
);
    fpx_mode_t    mode;
    fpx_stat_t    stat;
    fpx_verdict_t verdict_d;
    fpx_verdict_t verdict_q;

    assign mode.nrm_off  = md_nrm_off;
    assign mode.uf_trap  = md_uf_trap;
    assign mode.sig_trap = md_sig_trap;

    fpx_stat_pack #(
        .SHIFT_W   (SHIFT_W),
        .SIG_LIMIT (SIG_LIMIT)
    ) stat_i (
        .sign      (res_sign),
        .is_zero   (res_zero),
        .underflow (res_underflow),
        .lshift    (res_lshift),
        .stat      (stat)
    );

    fpx_decide decide_i (
        .mode    (mode),
        .stat    (stat),
        .verdict (verdict_d)
    );

    fpx_out_stage out_i (
        .clk       (clk),
        .rst       (rst),
        .load      (in_valid),
        .verdict_d (verdict_d),
        .valid_q   (out_valid),
        .verdict_q (verdict_q)
    );

    assign cc              = verdict_q.cc;
    assign force_true_zero = verdict_q.force_zero;
    assign trap_req        = verdict_q.trap;
    assign gr_write_en     = verdict_q.gr_write;
    assign trap_vector     = TRAP_VEC;
endmodule

// File: rtl/fpx_cc_ctrl_chk.sv
module fpx_cc_ctrl_chk #(
    parameter int SHIFT_W   = 3,
    parameter int SIG_LIMIT = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               res_sign,
    input logic               res_zero,
    input logic               res_underflow,
    input logic [SHIFT_W-1:0] res_lshift,
    input logic               md_nrm_off,
    input logic               md_uf_trap,
    input logic               md_sig_trap,
    input logic               out_valid,
    input logic [3:0]         cc,
    input logic               force_true_zero,
    input logic               trap_req,
    input logic               gr_write_en
);
    logic sig_cond;
    assign sig_cond = res_zero || (res_lshift > SHIFT_W'(SIG_LIMIT));

    assert_trap_excl_R10: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> !gr_write_en);

    assert_valid_follow_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(cc) && $stable(trap_req) && $stable(force_true_zero)));

    assert_no_trap_inhibit_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && md_nrm_off) |=> (!trap_req && gr_write_en && cc[3:2] == 2'b00));

    assert_uf_trap_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !md_nrm_off && res_underflow && md_uf_trap)
            |=> (trap_req && cc[3:2] == 2'b11 && !force_true_zero));

    assert_uf_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !md_nrm_off && res_underflow && !md_uf_trap && !(md_sig_trap && sig_cond))
            |=> (force_true_zero && cc == 4'b1100 && !trap_req));

    assert_sig_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !md_nrm_off && md_sig_trap && sig_cond && !md_uf_trap)
            |=> (trap_req && cc[3:2] == 2'b10 && !force_true_zero));
endmodule

bind fpx_cc_ctrl fpx_cc_ctrl_chk #(
    .SHIFT_W   (SHIFT_W),
    .SIG_LIMIT (SIG_LIMIT)
) chk_i (
    .clk             (clk),
    .rst             (rst),
    .in_valid        (in_valid),
    .res_sign        (res_sign),
    .res_zero        (res_zero),
    .res_underflow   (res_underflow),
    .res_lshift      (res_lshift),
    .md_nrm_off      (md_nrm_off),
    .md_uf_trap      (md_uf_trap),
    .md_sig_trap     (md_sig_trap),
    .out_valid       (out_valid),
    .cc              (cc),
    .force_true_zero (force_true_zero),
    .trap_req        (trap_req),
    .gr_write_en     (gr_write_en)
);

// File: tb/fpx_cc_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpx_cc_ctrl_tb_top;
    localparam int SHIFT_W = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               res_sign = 1'b0;
    logic               res_zero = 1'b0;
    logic               res_underflow = 1'b0;
    logic [SHIFT_W-1:0] res_lshift = '0;
    logic               md_nrm_off = 1'b0;
    logic               md_uf_trap = 1'b0;
    logic               md_sig_trap = 1'b0;
    logic               out_valid;
    logic [3:0]         cc;
    logic               force_true_zero;
    logic               trap_req;
    logic               gr_write_en;
    logic [7:0]         trap_vector;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    fpx_cc_ctrl dut_i (
        .clk             (clk),
        .rst             (rst),
        .in_valid        (in_valid),
        .res_sign        (res_sign),
        .res_zero        (res_zero),
        .res_underflow   (res_underflow),
        .res_lshift      (res_lshift),
        .md_nrm_off      (md_nrm_off),
        .md_uf_trap      (md_uf_trap),
        .md_sig_trap     (md_sig_trap),
        .out_valid       (out_valid),
        .cc              (cc),
        .force_true_zero (force_true_zero),
        .trap_req        (trap_req),
        .gr_write_en     (gr_write_en),
        .trap_vector     (trap_vector)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected verdict from the requirements; packs {cc, trap, wr, fz}
    function automatic logic [6:0] expect_of(input bit s, input bit z, input bit u,
                                             input int sh, input bit inh, input bit fzm,
                                             input bit fsm, output string req);
        bit sig;
        logic [3:0] c;
        bit tr, fz;
        sig = z || (sh > 2);
        tr = 0; fz = 0;
        if (inh) begin
            req = "R1";
            if (z) begin c = 4'b0000; fz = 1; end
            else c = s ? 4'b0001 : 4'b0010;
        end else if (fsm && sig && !(u && fzm)) begin
            req = u ? "R8" : "R7";
            tr = 1;
            c = z ? 4'b1000 : (s ? 4'b1001 : 4'b1010);
        end else if (u && fzm) begin
            req = (fsm && sig) ? "R9" : "R4";
            tr = 1;
            c = s ? 4'b1101 : 4'b1110;
        end else if (u) begin
            req = "R3"; c = 4'b1100; fz = 1;
        end else if (z) begin
            req = "R5"; c = 4'b1000; fz = 1;
        end else if (sh > 2) begin
            req = "R6"; c = s ? 4'b1001 : 4'b1010;
        end else begin
            req = "R2"; c = s ? 4'b0001 : 4'b0010;
        end
        return {c, tr, !tr, fz};
    endfunction

    task automatic run_one(input bit s, input bit z, input bit u, input int sh,
                           input bit inh, input bit fzm, input bit fsm);
        string req;
        logic [6:0] e;
        e = expect_of(s, z, u, sh, inh, fzm, fsm, req);
        res_sign = s; res_zero = z; res_underflow = u;
        res_lshift = SHIFT_W'(sh);
        md_nrm_off = inh; md_uf_trap = fzm; md_sig_trap = fsm;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " verdict"}, {1'b0, cc, trap_req, gr_write_en, force_true_zero},
              {1'b0, e});
        check("R11 out_valid", {7'd0, out_valid}, 8'd1);
        check("R10 excl", {7'd0, trap_req & gr_write_en}, 8'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [3:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset valid", {7'd0, out_valid}, 8'd0);
        check("R11 reset outs", {4'd0, cc}, 8'd0);
        check("R11 reset flags", {5'd0, trap_req, gr_write_en, force_true_zero}, 8'd0);
        check("R10 vector", trap_vector, 8'h44);

        // Directed corners: s, z, u, sh, inh, fzm, fsm
        run_one(0, 0, 0, 0, 0, 0, 0);   // R2 positive
        run_one(1, 0, 0, 2, 0, 0, 0);   // R2 negative, shift at limit
        run_one(0, 1, 0, 0, 1, 1, 1);   // R1 zero
        run_one(1, 0, 1, 5, 1, 1, 1);   // R1 negative, others ignored
        run_one(0, 0, 1, 7, 1, 0, 1);   // R1 positive, others ignored
        run_one(0, 0, 1, 1, 0, 0, 0);   // R3
        run_one(1, 0, 1, 1, 0, 0, 1);   // R3 with sig mode, no sig condition
        run_one(0, 0, 1, 0, 0, 1, 0);   // R4 positive
        run_one(1, 0, 1, 0, 0, 1, 0);   // R4 negative
        run_one(1, 1, 0, 0, 0, 0, 0);   // R5
        run_one(0, 0, 0, 3, 0, 0, 0);   // R6 positive, just over limit
        run_one(1, 0, 0, 7, 0, 1, 0);   // R6 negative
        run_one(0, 1, 0, 0, 0, 0, 1);   // R7 zero
        run_one(0, 0, 0, 3, 0, 1, 1);   // R7 positive
        run_one(1, 0, 0, 6, 0, 0, 1);   // R7 negative
        run_one(1, 0, 1, 4, 0, 0, 1);   // R8 underflow ignored
        run_one(0, 1, 1, 0, 0, 0, 1);   // R8 zero with underflow
        run_one(0, 0, 1, 4, 0, 1, 1);   // R9 positive
        run_one(1, 1, 1, 0, 0, 1, 1);   // R9 negative

        // R11 hold: idle with changed inputs
        held = cc;
        res_sign = ~res_sign; res_zero = 1'b1; md_nrm_off = 1'b1;
        @(negedge clk);
        check("R11 idle valid", {7'd0, out_valid}, 8'd0);
        check("R11 hold cc", {4'd0, cc}, {4'd0, held});

        for (int i = 0; i < 400; i++) begin
            bit rs, rz, ru, ri, rf, rg;
            int rsh;
            rs  = 1'($urandom_range(0, 1));
            rz  = ($urandom_range(0, 3) == 0);
            ru  = ($urandom_range(0, 2) == 0);
            rsh = int'($urandom_range(0, 7));
            ri  = ($urandom_range(0, 3) == 0);
            rf  = 1'($urandom_range(0, 1));
            rg  = 1'($urandom_range(0, 1));
            run_one(rs, rz, ru, rsh, ri, rf, rg);
            if ($urandom_range(0, 4) == 0) begin
                held = cc;
                @(negedge clk);
                check("R11 hold", {4'd0, cc}, {4'd0, held});
            end
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule